// File: doc/BRIEF.md
# Radio Transceiver SPI Register Accessor

This block is an SPI master that gives a host byte-level access to the registers of a radio transceiver. The host places one command on a valid/ready command port. The command carries an access kind, a 6-bit register address and, for burst kinds, a byte count. The block then drops chip select and waits for the slave to pull MISO low, which means it is ready. It shifts out a header byte, runs the data phase and releases chip select. The byte the slave returns during the header is the slave's status byte. That byte, and every byte read in the data phase, goes back to the host on a valid/ready response port.

Write data comes in on a valid/ready write port. Both byte ports carry back-pressure, and the block has no internal buffer. While a response byte is still waiting for the host, the block issues no further SPI clock edges. While a write byte is missing, the block holds chip select low with the clock idle until the byte arrives. Either stall lengthens the transaction but cannot lose a byte. The slave ready timeout, the gap after the header and the gap between data bytes are plain configuration inputs. They must be held constant for the length of a transaction. The SPI clock half-period is a parameter. A one-cycle done pulse marks the release of chip select, and an error flag travels with that pulse when the ready wait timed out.

Top module: `radio_spi_accessor`

## Requirements
- R1: The header byte carries a read flag in bit 7, a burst flag in bit 6 and the address in bits 5:0. Access kind 0 (single write) gives 0x00|addr. Kind 1 (burst write) gives 0x40|addr. Kind 2 (single read) gives 0x80|addr. Kind 3 (burst read) and kind 4 (status read) give 0xC0|addr. Kind 5 (strobe), and the unused codes 6 and 7, give 0x00|addr.
- R2: After chip select falls, no rising SCLK edge occurs until MISO has been seen low.
- R3: The block samples MISO for at most cfg_timeout+1 consecutive cycles. If MISO stays high for all of them, chip select is released and done and timeout_err pulse together. No SCLK edge occurs and no response byte is produced.
- R4: SPI mode 0. SCLK is low whenever chip select is high. Each byte goes out MSB first. MOSI changes only while SCLK is low, and MISO is sampled when SCLK rises. SCLK stays high for exactly HALF_DIV clock cycles per bit.
- R5: The byte returned during the header is the first response of every transaction that reaches the header. It is flagged with rsp_status=1, and all later response bytes carry rsp_status=0.
- R6: A strobe (kind 5) shifts only the header byte, returns only the status byte and then releases chip select.
- R7: A status read (kind 4) shifts the header and exactly one data byte, and returns the status byte followed by the byte read.
- R8: A burst access (kind 1 or 3) keeps chip select low across the header and exactly cmd_len data bytes. A cmd_len of 0 means header only. Between two data bytes, SCLK stays low for at least cfg_byte_gap+HALF_DIV cycles.
- R9: Between the header byte and the first data byte, SCLK stays low for at least cfg_hdr_gap+HALF_DIV cycles.
- R10: After each transaction, chip select is high, SCLK low and MOSI low. The done output is high for exactly the one cycle in which chip select has just gone high, and cmd_ready is high only while chip select is high.
- R11: A response byte stays valid and unchanged until it is accepted. wr_ready is high only while chip select is low.
- R12: Write data bytes go out after the header in the order they were accepted. The read data phase shifts out 0x00 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_kind | input | 3 | Access kind code (see R1) |
| cmd_addr | input | 6 | Register address |
| cmd_len | input | LEN_W | Data byte count for burst kinds |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Block takes the write byte |
| wr_data | input | 8 | Write byte |
| rsp_valid | output | 1 | Response byte available |
| rsp_ready | input | 1 | Host takes the response byte |
| rsp_data | output | 8 | Response byte |
| rsp_status | output | 1 | Response byte is the slave status byte |
| cfg_timeout | input | TMO_W | Ready-wait limit in cycles, minus one |
| cfg_hdr_gap | input | GAP_W | Extra idle cycles after the header |
| cfg_byte_gap | input | GAP_W | Extra idle cycles between data bytes |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Master data out |
| spi_miso | input | 1 | Slave data in and ready indication |
| done | output | 1 | One-cycle pulse on chip select release |
| timeout_err | output | 1 | Pulses with done when the ready wait expired |

## Verification
The bench builds the block with HALF_DIV=2, LEN_W=5, TMO_W=8 and GAP_W=6. These values keep one bit at four clock cycles, so the exact high-time check and the minimum gap checks become cycle-precise at a small cost in run time. Bursts of up to 31 bytes fit within the length field, and the bench drives them up to 12 bytes. Short timeouts together with a slave that never drops MISO make the error path quick to reach. Gaps of up to 63 cycles can be chosen at run time, so a long header gap can be set against a zero byte gap.

// File: rtl/rsa_pkg.sv
package rsa_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 6;
  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    K_WR_ONE  = 3'd0,
    K_WR_RUN  = 3'd1,
    K_RD_ONE  = 3'd2,
    K_RD_RUN  = 3'd3,
    K_STAT    = 3'd4,
    K_STROBE  = 3'd5
  } rsa_kind_e;
endpackage

// File: rtl/rsa_hdr_enc.sv
module rsa_hdr_enc
  import rsa_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  output logic [BYTE_W-1:0] hdr,
  output logic [LEN_W-1:0]  nbytes,
  output logic              is_read
);
  logic rd_flag, run_flag;

  always_comb begin
    rd_flag  = 1'b0;
    run_flag = 1'b0;
    nbytes   = '0;
    case (kind)
      K_WR_ONE: nbytes = LEN_W'(1);
      K_WR_RUN: begin run_flag = 1'b1; nbytes = len; end
      K_RD_ONE: begin rd_flag = 1'b1; nbytes = LEN_W'(1); end
      K_RD_RUN: begin rd_flag = 1'b1; run_flag = 1'b1; nbytes = len; end
      K_STAT:   begin rd_flag = 1'b1; run_flag = 1'b1; nbytes = LEN_W'(1); end
      default:  nbytes = '0;
    endcase
    hdr     = {rd_flag, run_flag, addr};
    is_read = rd_flag;
  end
endmodule

// File: rtl/rsa_byte_shifter.sv
module rsa_byte_shifter
  import rsa_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);
  localparam int BIT_W = $clog2(BYTE_W);

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      rx   <= '0;
      sclk <= 1'b0;
      mosi <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx;
          mosi <= tx[BYTE_W-1];
          cnt  <= '0;
          bitn <= '0;
        end
      end else if (!sclk) begin
        if (cnt == CNT_LAST) begin
          sclk <= 1'b1;
          cnt  <= '0;
          rx   <= {rx[BYTE_W-2:0], miso};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == CNT_LAST) begin
          sclk <= 1'b0;
          cnt  <= '0;
          if (bitn == BIT_W'(BYTE_W - 1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[BYTE_W-2:0], 1'b0};
            mosi <= sh[BYTE_W-2];
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // MOSI may only move while the clock is low
  assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));
  // a started byte is always finished by a falling clock edge
  assert_done_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!sclk && $past(sclk)));
endmodule

// File: rtl/rsa_ctrl.sv
module rsa_ctrl
  import rsa_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int TMO_W = 8,
  parameter int GAP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [BYTE_W-1:0] enc_hdr,
  input  logic [LEN_W-1:0]  enc_nbytes,
  input  logic              enc_read,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_status,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [GAP_W-1:0]  cfg_hdr_gap,
  input  logic [GAP_W-1:0]  cfg_byte_gap,
  input  logic              miso,
  output logic              cs_n,
  output logic              sh_start,
  output logic [BYTE_W-1:0] sh_tx,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rx,
  output logic              done,
  output logic              timeout_err
);
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_XFER, S_AFTER, S_GAP, S_NEEDWR, S_FIN
  } st_e;

  st_e               st;
  logic [BYTE_W-1:0] hdr_q;
  logic [LEN_W-1:0]  remain;
  logic              rd_mode, hdr_phase, tmo_hit;
  logic [TMO_W-1:0]  tcnt;
  logic [GAP_W-1:0]  gcnt, gap_sel;
  logic              gap_ok;

  assign cmd_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_NEEDWR);
  assign gap_sel   = hdr_phase ? cfg_hdr_gap : cfg_byte_gap;
  assign gap_ok    = (gcnt >= gap_sel);

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = '0;
    case (st)
      S_WAIT:   if (!miso) begin sh_start = 1'b1; sh_tx = hdr_q; end
      S_GAP:    if (gap_ok && rd_mode) sh_start = 1'b1;
      S_NEEDWR: if (wr_valid) begin sh_start = 1'b1; sh_tx = wr_data; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hdr_q       <= '0;
      remain      <= '0;
      rd_mode     <= 1'b0;
      hdr_phase   <= 1'b0;
      tmo_hit     <= 1'b0;
      tcnt        <= '0;
      gcnt        <= '0;
      cs_n        <= 1'b1;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_status  <= 1'b0;
    end else begin
      done        <= 1'b0;
      timeout_err <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          hdr_q     <= enc_hdr;
          remain    <= enc_nbytes;
          rd_mode   <= enc_read;
          hdr_phase <= 1'b1;
          tmo_hit   <= 1'b0;
          tcnt      <= '0;
          cs_n      <= 1'b0;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (!miso) st <= S_XFER;
          else if (tcnt == cfg_timeout) begin
            tmo_hit <= 1'b1;
            st      <= S_FIN;
          end else tcnt <= tcnt + 1'b1;
        end
        S_XFER: if (sh_done) begin
          if (hdr_phase || rd_mode) begin
            rsp_valid  <= 1'b1;
            rsp_data   <= sh_rx;
            rsp_status <= hdr_phase;
          end
          st <= S_AFTER;
        end
        S_AFTER: if (!rsp_valid) begin
          if (remain == '0) st <= S_FIN;
          else begin
            gcnt <= '0;
            st   <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_ok) begin
            if (rd_mode) begin
              remain    <= remain - 1'b1;
              hdr_phase <= 1'b0;
              st        <= S_XFER;
            end else st <= S_NEEDWR;
          end else gcnt <= gcnt + 1'b1;
        end
        S_NEEDWR: if (wr_valid) begin
          remain    <= remain - 1'b1;
          hdr_phase <= 1'b0;
          st        <= S_XFER;
        end
        S_FIN: begin
          cs_n        <= 1'b1;
          done        <= 1'b1;
          timeout_err <= tmo_hit;
          st          <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cmd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cs_n);
  assert_done_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !$past(cs_n)));
  assert_err_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_status)));
  assert_wr_in_txn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !cs_n);
  assert_no_byte_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !rsp_valid);
endmodule

// File: rtl/radio_spi_accessor.sv
module radio_spi_accessor
  import rsa_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int LEN_W    = 5,
  parameter int TMO_W    = 8,
  parameter int GAP_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [KIND_W-1:0] cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [BYTE_W-1:0] rsp_data,
  output logic              rsp_status,
  input  logic [TMO_W-1:0]  cfg_timeout,
  input  logic [GAP_W-1:0]  cfg_hdr_gap,
  input  logic [GAP_W-1:0]  cfg_byte_gap,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              done,
  output logic              timeout_err
);
  logic [BYTE_W-1:0] enc_hdr, sh_tx, sh_rx;
  logic [LEN_W-1:0]  enc_nbytes;
  logic              enc_read, sh_start, sh_done;

  rsa_hdr_enc #(.LEN_W(LEN_W)) u_enc (
    .kind(cmd_kind), .addr(cmd_addr), .len(cmd_len),
    .hdr(enc_hdr), .nbytes(enc_nbytes), .is_read(enc_read)
  );

  rsa_ctrl #(.LEN_W(LEN_W), .TMO_W(TMO_W), .GAP_W(GAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .enc_hdr(enc_hdr), .enc_nbytes(enc_nbytes), .enc_read(enc_read),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status),
    .cfg_timeout(cfg_timeout), .cfg_hdr_gap(cfg_hdr_gap), .cfg_byte_gap(cfg_byte_gap),
    .miso(spi_miso), .cs_n(spi_cs_n),
    .sh_start(sh_start), .sh_tx(sh_tx), .sh_done(sh_done), .sh_rx(sh_rx),
    .done(done), .timeout_err(timeout_err)
  );

  rsa_byte_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  assert_clk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);
  assert_idle_mosi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && cmd_ready) |-> !spi_mosi);
endmodule

// File: tb/sim_radio_spi_accessor.sv
module sim_radio_spi_accessor;
  localparam int HD = 2, LW = 5, TW = 8, GW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_kind = '0;
  logic [5:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0;
  logic wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic rsp_valid, rsp_ready = 1'b0, rsp_status;
  logic [7:0] rsp_data;
  logic [TW-1:0] cfg_timeout = '0;
  logic [GW-1:0] cfg_hdr_gap = '0, cfg_byte_gap = '0;
  logic spi_cs_n, spi_sclk, spi_mosi, spi_miso = 1'b1;
  logic done, timeout_err;

  radio_spi_accessor #(.HALF_DIV(HD), .LEN_W(LW), .TMO_W(TW), .GAP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_status(rsp_status), .cfg_timeout(cfg_timeout), .cfg_hdr_gap(cfg_hdr_gap),
    .cfg_byte_gap(cfg_byte_gap), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .done(done), .timeout_err(timeout_err)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  // ---------------- slave model ----------------
  logic [7:0] sl_bytes [0:39];
  int sl_b = 0, sl_k = 0, rdy_delay = 1;
  bit sl_ready = 1'b0, never_ready = 1'b0;

  always @(negedge spi_cs_n) begin
    sl_b = 0; sl_k = 0; sl_ready = 1'b0; spi_miso = 1'b1;
    if (!never_ready) begin
      repeat (rdy_delay) @(negedge clk);
      if (!spi_cs_n) begin
        spi_miso = sl_bytes[0][7];
        sl_ready = 1'b1;
      end
    end
  end
  always @(posedge spi_cs_n) spi_miso = 1'b1;
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin
    sl_b++;
    if (sl_b == 8) begin sl_b = 0; sl_k++; end
    if (sl_k < 40) spi_miso = sl_bytes[sl_k][7-sl_b];
  end

  logic [7:0] mlog [0:39];
  logic [7:0] msh = '0;
  int mcnt = 0, mbit = 0;
  always @(posedge spi_sclk) if (rst_n) begin
    if (!sl_ready) check(1'b0, "R2 clock before ready", 1, 0);
    msh = {msh[6:0], spi_mosi};
    mbit++;
    if (mbit == 8) begin
      if (mcnt < 40) mlog[mcnt] = msh;
      mcnt++; mbit = 0;
    end
  end

  // ---------------- line timing monitor ----------------
  int hi_run = 0, lo_run = 0, bits_seen = 0;
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n && spi_sclk) check(1'b0, "R4 sclk high with cs released", 1, 0);
    if (spi_sclk) begin
      if (prev_sclk && spi_mosi !== prev_mosi)
        check(1'b0, "R4 mosi moved during high phase", spi_mosi, prev_mosi);
      if (!prev_sclk) begin
        if (bits_seen == 8)
          check(lo_run >= int'(cfg_hdr_gap) + HD, "R9 header gap", lo_run, int'(cfg_hdr_gap) + HD);
        else if (bits_seen > 8 && bits_seen % 8 == 0)
          check(lo_run >= int'(cfg_byte_gap) + HD, "R8 byte gap", lo_run, int'(cfg_byte_gap) + HD);
        bits_seen++;
        hi_run = 1;
      end else hi_run++;
    end else begin
      if (prev_sclk) begin
        check(hi_run == HD, "R4 high time", hi_run, HD);
        lo_run = 1;
      end else lo_run++;
    end
    prev_sclk = spi_sclk;
    prev_mosi = spi_mosi;
  end

  // ---------------- host-side byte ports ----------------
  logic [7:0] rlog [0:39];
  logic rstat [0:39];
  int rcnt = 0;
  bit rsp_random = 1'b0;
  always @(negedge clk) if (rst_n) begin
    rsp_ready = rsp_random ? ($urandom % 3 != 0) : 1'b1;
    if (rsp_valid && rsp_ready) begin
      if (rcnt < 40) begin rlog[rcnt] = rsp_data; rstat[rcnt] = rsp_status; end
      rcnt++;
    end
  end

  logic [7:0] wq [0:39];
  int widx = 0, wtotal = 0;
  always @(negedge clk) if (rst_n) begin
    if (widx < wtotal) begin
      wr_valid = ($urandom % 4 != 0);
      wr_data  = wq[widx];
      if (wr_valid && wr_ready) widx++;
    end else wr_valid = 1'b0;
  end

  // ---------------- expected values from the requirements ----------------
  function automatic logic [7:0] exp_hdr(input int kind, input int addr);
    logic [1:0] top;
    case (kind)
      0: top = 2'b00; 1: top = 2'b01; 2: top = 2'b10;
      3, 4: top = 2'b11;
      default: top = 2'b00;
    endcase
    return {top, 6'(addr)};
  endfunction
  function automatic int exp_n(input int kind, input int len);
    case (kind)
      0, 2, 4: return 1;
      1, 3: return len;
      default: return 0;
    endcase
  endfunction
  function automatic bit exp_rd(input int kind);
    return (kind == 2 || kind == 3 || kind == 4);
  endfunction

  task automatic run(input int kind, input int addr, input int len, input int hg, input int bg,
                     input int tmo, input int d, input bit never, input bit rrand);
    int n, waited;
    bit rd;
    n  = exp_n(kind, len);
    rd = exp_rd(kind);
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      sl_bytes[i] = 8'($urandom);
      wq[i] = 8'($urandom);
    end
    sl_bytes[0][7] = 1'b0;
    cfg_timeout = TW'(tmo); cfg_hdr_gap = GW'(hg); cfg_byte_gap = GW'(bg);
    rdy_delay = d; never_ready = never; rsp_random = rrand;
    mcnt = 0; mbit = 0; rcnt = 0; bits_seen = 0;
    widx = 0; wtotal = rd ? 0 : n;
    cmd_kind = 3'(kind); cmd_addr = 6'(addr); cmd_len = LW'(len);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    check(done == 1'b1, "R10 done seen", done, 1);
    check(spi_cs_n && !spi_sclk && !spi_mosi, "R10 idle lines after txn",
          {spi_cs_n, spi_sclk, spi_mosi}, 3'b100);
    if (never) begin
      check(timeout_err == 1'b1, "R3 timeout flag", timeout_err, 1);
      check(mcnt == 0 && mbit == 0, "R3 no clock on timeout", mcnt * 8 + mbit, 0);
      check(rcnt == 0, "R3 no response on timeout", rcnt, 0);
    end else begin
      check(timeout_err == 1'b0, "R3 no timeout flag", timeout_err, 0);
      check(mcnt == 1 + n && mbit == 0, "R8 byte count on line", mcnt, 1 + n);
      check(mlog[0] == exp_hdr(kind, addr), "R1 header byte", mlog[0], exp_hdr(kind, addr));
      for (int i = 1; i <= n && i < 40; i++) begin
        if (rd) check(mlog[i] == 8'h00, "R12 read dummy byte", mlog[i], 0);
        else    check(mlog[i] == wq[i-1], "R12 write byte order", mlog[i], wq[i-1]);
      end
      check(rcnt == 1 + (rd ? n : 0), "R6 response count", rcnt, 1 + (rd ? n : 0));
      check(rlog[0] == sl_bytes[0] && rstat[0] == 1'b1, "R5 status byte first",
            {rstat[0], rlog[0]}, {1'b1, sl_bytes[0]});
      if (rd) for (int i = 1; i <= n && i < 40; i++)
        check(rlog[i] == sl_bytes[i] && rstat[i] == 1'b0, "R7 read byte",
              {rstat[i], rlog[i]}, {1'b0, sl_bytes[i]});
    end
    @(negedge clk);
    check(done == 1'b0, "R10 done is one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 40; i++) begin sl_bytes[i] = '0; wq[i] = '0; end
    repeat (3) @(negedge clk);
    check(spi_cs_n && !spi_sclk && !spi_mosi && !rsp_valid && !done,
          "R10 reset lines", {spi_cs_n, spi_sclk, spi_mosi, rsp_valid, done}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && wr_ready == 1'b0, "R10 ready after reset", {cmd_ready, wr_ready}, 2'b10);

    // directed corners
    run(5, 6'h36, 0, 0, 0, 20, 3, 1'b0, 1'b0);   // R6 strobe
    run(4, 6'h3A, 0, 2, 0, 20, 1, 1'b0, 1'b0);   // R7 status read
    run(1, 6'h3F, 0, 1, 1, 20, 2, 1'b0, 1'b0);   // R8 burst of zero bytes
    run(3, 6'h3F, 12, 20, 0, 20, 5, 1'b0, 1'b1); // R8 R9 long header gap, stalled responses
    run(1, 6'h3E, 12, 0, 7, 20, 4, 1'b0, 1'b0);  // R8 R12 burst write with gaps
    run(2, 6'h0D, 0, 0, 0, 6, 7, 1'b0, 1'b0);    // R2 ready just inside the limit
    run(0, 6'h05, 0, 0, 0, 5, 0, 1'b1, 1'b0);    // R3 slave never ready
    run(7, 6'h31, 3, 0, 0, 20, 2, 1'b0, 1'b0);   // R1 unused code acts as strobe

    // constrained random mix
    for (int t = 0; t < 45; t++) begin
      int k, a, l;
      k = $urandom % 6;
      a = (k >= 4) ? (6'h30 + $urandom % 14) : ($urandom % 64);
      l = $urandom % 9;
      run(k, a, l, $urandom % 6, $urandom % 6, 16, 1 + $urandom % 10,
          ($urandom % 12 == 0), $urandom % 2);
    end
    summary();
  end
endmodule